// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block sits between a simple on-chip request port and an external asynchronous static RAM with an 18-bit word address and a 16-bit data word split into two byte lanes. It turns each accepted request into a sequence of active-low strobes (chip select, write enable, output enable and one enable per byte lane), timed in whole clock cycles so the RAM's minimum setup, pulse, hold and access windows are always met.

Every window is written in nanoseconds as a parameter and turned into a cycle count from the clock period. A count is always rounded up, and a window specified as zero still takes one cycle. A write raises chip select first, then pulses write enable, then holds chip select and data. A read holds chip select and output enable low for the access window and captures the bus on its last cycle. The data bus is brought out as a drive value, a per-lane drive enable and an input, so the pad ring can build the three-state buffer. One request is in flight at a time, and completion is a single-cycle done pulse.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, chip select, write enable, output enable and both byte enables are high (inactive), no lane drives the bus, done is low, ready is high and the read data output is zero.
- R2: A request is accepted only on a clock edge where ready is high. A request held high while an access is in progress, or in its done cycle, is ignored and changes neither the pins nor the memory.
- R3: A write holds chip select low with write enable high for S cycles, then has write enable low for P cycles, then write enable high with chip select still low for H cycles. S is the address setup time rounded up to cycles (minimum 1), P is the larger of the write pulse and the data-to-end-of-write time rounded up, and H is the data hold time rounded up (minimum 1). With a 4 ns clock these are 1, 4 and 1.
- R4: From the first to the last cycle with chip select low, the address pins hold the accepted address, and every driven lane holds the accepted write data.
- R5: Output enable stays high for a whole write, and no lane drives the bus in any cycle where output enable is low.
- R6: Request mask bit 1 selects the upper lane (data bits 15..8, byte enable bit 1) and bit 0 selects the lower lane (bits 7..0, byte enable bit 0). A lane's byte enable is low and, for a write, the lane is driven only when its mask bit is 1. A mask of 00 lowers no byte enable, so the memory is left unchanged.
- R7: A read holds chip select and output enable low with write enable high for A cycles and drives no lane. A is the largest of the read cycle, address access, output-enable access and byte-enable access times rounded up (5 at 4 ns).
- R8: Read data is captured on the last read-access cycle. A lane whose mask bit is 0 returns zero. The value appears together with the done pulse and holds until the next read completes.
- R9: Exactly one done cycle follows each access, with all strobes high and no lane driven, and ready returns in the next cycle.
- R10: The number of cycles with chip select low in a write, S+P+H, is at least the minimum write cycle time rounded up to cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid, taken only while ready_o is high |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Lane mask, bit 1 upper byte, bit 0 lower byte |
| ready_o | output | 1 | Controller idle, a request can be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data, valid with done_o and held |
| sram_addr_o | output | 18 | RAM address |
| sram_ce_no | output | 1 | RAM chip select, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_be_no | output | 2 | RAM byte enables, active low, bit 1 upper |
| sram_dq_o | output | 16 | Data driven toward the RAM |
| sram_dq_oe_o | output | 2 | Per-lane drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data read from the RAM bus |

## Verification
All strobe outputs are registered from the next state, so the first strobe cycle of an access appears right after the rising edge that accepts the request. Done follows S+P+H cycles later for a write and A cycles later for a read, and read data changes on that same edge. The bench reference model moves forward one cycle on each rising edge, from the request it saw at that edge, and the pins, address, driven data and read data are compared against it at the falling edge of every cycle. Expected read data comes from the bench's own copy of the memory, while a separate pin-level RAM model takes writes only during the chip-select, write-enable and byte-enable overlap.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_DONE
  } state_e;

  // ceil(ns / per), never below one cycle
  function automatic int ns2cyc(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 4,
  parameter int HOLD_CYC  = 1,
  parameter int ACC_CYC   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  output logic accept_o,
  output logic ready_o,
  output logic ce_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic act_o,
  output logic drv_o,
  output logic capture_o,
  output logic done_o
);
  state_e        state_q, state_d;
  logic          load, last;
  logic [CW-1:0] load_val;

  sram_ctl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o && req_i;
  assign capture_o = (state_q == ST_RACC) && last;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        load = 1'b1;
        if (we_i) begin
          state_d  = ST_WSETUP;
          load_val = CW'(SETUP_CYC - 1);
        end else begin
          state_d  = ST_RACC;
          load_val = CW'(ACC_CYC - 1);
        end
      end
      ST_WSETUP: if (last) begin
        state_d  = ST_WPULSE;
        load     = 1'b1;
        load_val = CW'(WP_CYC - 1);
      end
      ST_WPULSE: if (last) begin
        state_d  = ST_WHOLD;
        load     = 1'b1;
        load_val = CW'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (last) state_d = ST_DONE;
      ST_RACC:  if (last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      act_o   <= 1'b0;
      drv_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_o  <= !(state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC});
      we_n_o  <= (state_d != ST_WPULSE);
      oe_n_o  <= (state_d != ST_RACC);
      act_o   <= (state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC});
      drv_o   <= (state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
      done_o  <= (state_d == ST_DONE);
    end
  end
endmodule

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          en_i,
  input  logic [LW-1:0] wdata_i,
  input  logic          act_i,
  input  logic          drv_i,
  input  logic          capture_i,
  input  logic [LW-1:0] dq_i,
  output logic          be_n_o,
  output logic [LW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [LW-1:0] rdata_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      dq_o    <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        en_q <= en_i;
        dq_o <= wdata_i;
      end
      if (capture_i) rdata_o <= en_q ? dq_i : '0;
    end
  end

  assign be_n_o  = !(act_i && en_q);
  assign dq_oe_o = drv_i && en_q;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int CLK_NS  = 4,
  parameter int T_AS_NS = 0,
  parameter int T_WP_NS = 15,
  parameter int T_DW_NS = 10,
  parameter int T_DH_NS = 0,
  parameter int T_WC_NS = 20,
  parameter int T_RC_NS = 20,
  parameter int T_AA_NS = 20,
  parameter int T_OE_NS = 10,
  parameter int T_BA_NS = 10,
  parameter int CW      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW/8-1:0]    be_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [DW-1:0]      rdata_o,
  output logic [AW-1:0]      sram_addr_o,
  output logic               sram_ce_no,
  output logic               sram_we_no,
  output logic               sram_oe_no,
  output logic [DW/8-1:0]    sram_be_no,
  output logic [DW-1:0]      sram_dq_o,
  output logic [DW/8-1:0]    sram_dq_oe_o,
  input  logic [DW-1:0]      sram_dq_i
);
  localparam int LW        = 8;
  localparam int LANES     = DW / LW;
  localparam int SETUP_CYC = ns2cyc(T_AS_NS, CLK_NS);
  localparam int WP_CYC    = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS));
  localparam int HOLD_CYC  = imax(ns2cyc(T_DH_NS, CLK_NS),
                                  ns2cyc(T_WC_NS, CLK_NS) - SETUP_CYC - WP_CYC);
  localparam int ACC_CYC   = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                  imax(ns2cyc(T_OE_NS, CLK_NS), ns2cyc(T_BA_NS, CLK_NS)));

  logic accept, act, drv, capture;

  sram_ctl_fsm #(
    .CW(CW), .SETUP_CYC(SETUP_CYC), .WP_CYC(WP_CYC),
    .HOLD_CYC(HOLD_CYC), .ACC_CYC(ACC_CYC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .accept_o  (accept),
    .ready_o   (ready_o),
    .ce_n_o    (sram_ce_no),
    .we_n_o    (sram_we_no),
    .oe_n_o    (sram_oe_no),
    .act_o     (act),
    .drv_o     (drv),
    .capture_o (capture),
    .done_o    (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sram_addr_o <= '0;
    else if (accept) sram_addr_o <= addr_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_ctl_lane #(.LW(LW)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .accept_i  (accept),
      .en_i      (be_i[l]),
      .wdata_i   (wdata_i[l*LW +: LW]),
      .act_i     (act),
      .drv_i     (drv),
      .capture_i (capture),
      .dq_i      (sram_dq_i[l*LW +: LW]),
      .be_n_o    (sram_be_no[l]),
      .dq_o      (sram_dq_o[l*LW +: LW]),
      .dq_oe_o   (sram_dq_oe_o[l]),
      .rdata_o   (rdata_o[l*LW +: LW])
    );
  end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW     = 18,
  parameter int LANES  = 2,
  parameter int WP_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             done_o,
  input logic [AW-1:0]    sram_addr_o,
  input logic             sram_ce_no,
  input logic             sram_we_no,
  input logic             sram_oe_no,
  input logic [LANES-1:0] sram_be_no,
  input logic [LANES-1:0] sram_dq_oe_o
);
  logic [15:0] wl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wl_cnt <= '0;
    else if (!sram_we_no) wl_cnt <= wl_cnt + 1'b1;
    else                  wl_cnt <= '0;
  end

  a_r5_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (sram_dq_oe_o == '0));
  a_r5_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);
  a_r3_we_inside_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);
  a_r3_setup_before_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $past(!sram_ce_no));
  a_r3_hold_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> !sram_ce_no);
  a_r3_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (wl_cnt == 16'(WP_CYC)));
  a_r4_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));
  a_r6_drive_needs_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o & sram_be_no) == '0);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sram_ce_no && sram_we_no && sram_oe_no && sram_dq_oe_o == '0));
  a_r2_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && !done_o));
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .LANES(LANES), .WP_CYC(WP_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_be_no   (sram_be_no),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;
  localparam int TCK  = 4;
  localparam int S_C  = 1;                  // 0 ns setup -> 1 cycle
  localparam int P_C  = (15 + TCK - 1) / TCK;
  localparam int H_C  = 1;                  // 0 ns hold -> 1 cycle
  localparam int A_C  = (20 + TCK - 1) / TCK;
  localparam int WC_C = (20 + TCK - 1) / TCK;
  // pin vector: ce we oe be_n[1:0] dq_oe[1:0] done ready
  localparam logic [8:0] V_IDLE = 9'b111_11_00_0_1;
  localparam logic [8:0] V_DONE = 9'b111_11_00_1_0;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #(TCK/2) clk_i = ~clk_i;

  logic        req_i = 1'b0, we_i = 1'b0;
  logic [17:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  be_i = '0;
  logic        ready_o, done_o;
  logic [15:0] rdata_o;
  logic [17:0] sram_addr_o;
  logic        sram_ce_no, sram_we_no, sram_oe_no;
  logic [1:0]  sram_be_no, sram_dq_oe_o;
  logic [15:0] sram_dq_o;
  logic [15:0] sram_dq_i = 16'hAAAA;

  sram_ctl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .ready_o(ready_o), .done_o(done_o),
    .rdata_o(rdata_o), .sram_addr_o(sram_addr_o), .sram_ce_no(sram_ce_no),
    .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no), .sram_be_no(sram_be_no),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o), .sram_dq_i(sram_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(int a);
    return 16'(a) ^ 16'h5A5A;
  endfunction

  logic [15:0] sram_mem [int];
  logic [15:0] ref_mem [int];

  // reference model, one step per rising edge
  logic [8:0]  q_vec [$];
  string       q_tag [$];
  logic [8:0]  cur = V_IDLE;
  string       cur_tag = "R1";
  bit          acc_evt = 0, op_we = 0;
  int          op_addr = 0, ce_cnt = 0;
  logic [15:0] op_wd = '0, op_rexp = '0, last_rexp = '0;
  logic [1:0]  op_be = '0;

  always @(posedge clk_i) begin
    logic [15:0] old;
    acc_evt = 0;
    if (!rst_ni) begin
      q_vec.delete(); q_tag.delete();
      cur = V_IDLE; cur_tag = "R1";
    end else if (q_vec.size() > 0) begin
      cur = q_vec.pop_front(); cur_tag = q_tag.pop_front();
    end else if (cur == V_IDLE && req_i) begin
      op_we = we_i; op_addr = int'(addr_i); op_wd = wdata_i; op_be = be_i;
      old = ref_mem.exists(op_addr) ? ref_mem[op_addr] : dflt(op_addr);
      if (we_i) begin
        ref_mem[op_addr] = {be_i[1] ? wdata_i[15:8] : old[15:8],
                            be_i[0] ? wdata_i[7:0]  : old[7:0]};
        for (int i = 0; i < S_C; i++) begin q_vec.push_back({3'b011, ~be_i, be_i, 2'b00}); q_tag.push_back("R3"); end
        for (int i = 0; i < P_C; i++) begin q_vec.push_back({3'b001, ~be_i, be_i, 2'b00}); q_tag.push_back("R6"); end
        for (int i = 0; i < H_C; i++) begin q_vec.push_back({3'b011, ~be_i, be_i, 2'b00}); q_tag.push_back("R5"); end
      end else begin
        op_rexp = {be_i[1] ? old[15:8] : 8'h00, be_i[0] ? old[7:0] : 8'h00};
        for (int i = 0; i < A_C; i++) begin q_vec.push_back({3'b010, ~be_i, 4'b0000}); q_tag.push_back("R7"); end
      end
      q_vec.push_back(V_DONE); q_tag.push_back("R9");
      cur = q_vec.pop_front(); cur_tag = q_tag.pop_front();
      acc_evt = 1;
    end else begin
      cur = V_IDLE; cur_tag = "R2";
    end
  end

  // compare at the falling edge, then run the pin-level RAM model
  always @(negedge clk_i) begin
    logic [8:0]  pins;
    logic [15:0] rd, w;
    if (rst_ni) begin
      pins = {sram_ce_no, sram_we_no, sram_oe_no, sram_be_no, sram_dq_oe_o, done_o, ready_o};
      chk(pins == cur, cur_tag, "strobe pins", longint'(pins), longint'(cur));
      chk(!(!sram_oe_no && (sram_dq_oe_o != 2'b00)), "R5", "bus contention",
          longint'(sram_dq_oe_o), 0);
      if (!cur[8]) begin
        chk(int'(sram_addr_o) == op_addr, "R4", "address", longint'(sram_addr_o), longint'(op_addr));
        if (cur[3]) chk(sram_dq_o[15:8] == op_wd[15:8], "R4", "upper write data",
                        longint'(sram_dq_o[15:8]), longint'(op_wd[15:8]));
        if (cur[2]) chk(sram_dq_o[7:0] == op_wd[7:0], "R4", "lower write data",
                        longint'(sram_dq_o[7:0]), longint'(op_wd[7:0]));
        if (op_we) ce_cnt++;
      end
      if (cur[1]) begin
        if (!op_we) begin
          chk(rdata_o == op_rexp, "R8", "read data", longint'(rdata_o), longint'(op_rexp));
          last_rexp = op_rexp;
        end else begin
          chk(rdata_o == last_rexp, "R8", "read data held", longint'(rdata_o), longint'(last_rexp));
          chk(ce_cnt == S_C + P_C + H_C && ce_cnt >= WC_C, "R10", "write cycle length",
              longint'(ce_cnt), longint'(S_C + P_C + H_C));
        end
        ce_cnt = 0;
      end
    end
    rd = sram_mem.exists(int'(sram_addr_o)) ? sram_mem[int'(sram_addr_o)] : dflt(int'(sram_addr_o));
    if (!sram_ce_no && !sram_we_no) begin
      w = rd;
      if (!sram_be_no[1]) w[15:8] = sram_dq_o[15:8];
      if (!sram_be_no[0]) w[7:0]  = sram_dq_o[7:0];
      sram_mem[int'(sram_addr_o)] = w;
      rd = w;
    end
    sram_dq_i = {(!sram_ce_no && !sram_oe_no && !sram_be_no[1]) ? rd[15:8] : 8'hAA,
                 (!sram_ce_no && !sram_oe_no && !sram_be_no[0]) ? rd[7:0]  : 8'hAA};
  end

  task automatic wait_idle();
    while (cur != V_IDLE) begin @(posedge clk_i); #1; end
  endtask

  task automatic issue(bit w, int a, logic [15:0] d, logic [1:0] b);
    req_i = 1'b1; we_i = w; addr_i = 18'(a); wdata_i = d; be_i = b;
    do begin @(posedge clk_i); #1; end while (!acc_evt);
    req_i = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values while reset is held
    chk({sram_ce_no, sram_we_no, sram_oe_no, sram_be_no, sram_dq_oe_o, done_o, ready_o} == V_IDLE,
        "R1", "pins in reset", longint'({sram_ce_no, sram_we_no, sram_oe_no, sram_be_no}), 5'h1F);
    chk(rdata_o == 16'h0, "R1", "rdata in reset", longint'(rdata_o), 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    issue(1, 32'h10, 16'h1234, 2'b11);
    issue(0, 32'h10, 16'h0, 2'b11);
    chk(rdata_o == 16'h1234, "R8", "full readback", longint'(rdata_o), 16'h1234);
    issue(1, 32'h10, 16'hABCD, 2'b10);            // R6 upper lane only
    issue(0, 32'h10, 16'h0, 2'b11);
    chk(rdata_o == 16'hAB34, "R6", "upper write merge", longint'(rdata_o), 16'hAB34);
    issue(0, 32'h10, 16'h0, 2'b01);
    chk(rdata_o == 16'h0034, "R8", "lower read only", longint'(rdata_o), 16'h0034);
    issue(0, 32'h10, 16'h0, 2'b10);
    chk(rdata_o == 16'hAB00, "R8", "upper read only", longint'(rdata_o), 16'hAB00);
    issue(1, 32'h10, 16'hFFFF, 2'b00);            // R6 empty mask changes nothing
    issue(0, 32'h10, 16'h0, 2'b11);
    chk(rdata_o == 16'hAB34, "R6", "empty mask write", longint'(rdata_o), 16'hAB34);
    issue(1, 32'h3FFFF, 16'hC3A5, 2'b11);
    issue(0, 32'h3FFFF, 16'h0, 2'b11);
    chk(rdata_o == 16'hC3A5, "R4", "top address", longint'(rdata_o), 16'hC3A5);

    // R2: request held high through a busy access is ignored
    req_i = 1'b1; we_i = 1'b0; addr_i = 18'h10; be_i = 2'b11;
    do begin @(posedge clk_i); #1; end while (!acc_evt);
    we_i = 1'b1; addr_i = 18'h155; wdata_i = 16'hDEAD;
    while (cur != V_DONE) begin @(posedge clk_i); #1; end
    req_i = 1'b0;
    wait_idle();
    issue(0, 32'h155, 16'h0, 2'b11);
    chk(rdata_o == dflt(32'h155), "R2", "busy request ignored", longint'(rdata_o),
        longint'(dflt(32'h155)));

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      issue(r[0], 32'h200 + int'(r[4:2]), r[31:16], r[6:5]);
    end
    repeat (3) @(posedge clk_i);
    finish_run();
  end
endmodule